// File: doc/BRIEF.md
# Sleep-State and Internal Reset Sequencer

This block decides when the core of a small 8-bit microcontroller runs, sleeps or is held in reset. Software raises a request bit to ask for idle or for power-down. The block then drives separate enables for the CPU clock, the peripheral clocks and the oscillator, together with the internal reset, a gate that keeps internal RAM from being accessed, a port-write enable, and weak pull-up enables for the port pins. Its inputs are the external reset pin, a vector of interrupts that are both enabled and pending, and a digital brown-out flag from an off-chip comparator. All of its logic runs on an always-on clock and is initialised by a power-on reset `por_n`.

The block is a Moore state machine with seven named states:
- RESET holds the internal reset.
- RUN is normal execution.
- IDLE stops only the CPU clock.
- IDLE_RST is a short window in which the CPU keeps running with RAM gated after a reset pin arrives during idle.
- PDOWN stops every clock and the oscillator.
- BROWN asserts the weak pull-ups while supply is low.
- BOD_DLY keeps reset asserted for a fixed number of ticks after supply recovers.

Transitions are checked in a fixed order on every clock edge:
1. IDLE_RST leaves only when its window ends (win_end), and then goes to RESET.
2. The reset pin moves IDLE to IDLE_RST (pin_in_idle) and moves any other state to RESET (pin_reset).
3. The brown-out flag moves any state to BROWN (bod_enter).
4. In RUN, a power-down request goes to PDOWN (pd_enter). Otherwise an idle request with no pending interrupt goes to IDLE (idle_enter).
5. A pending interrupt moves IDLE to RUN (irq_wake).
6. BROWN goes to BOD_DLY once the flag clears (bod_clear).
7. BOD_DLY goes to RUN when its count expires (bod_release).
8. RESET goes to RUN once the pin is low and its last assertion was long enough (rst_release).

Top module: `sleep_ctrl`

## Requirements
- R1: While `por_n` is low, the outputs take the RESET encoding: `int_rst`=1, `ram_inhibit`=1, `osc_en`=1, and `cpu_clk_en`, `per_clk_en`, `port_wr_en` and `weak_pu` all 0. The first clock edge after `por_n` rises with the pin low enters RUN. RUN drives `cpu_clk_en`=`per_clk_en`=`osc_en`=`port_wr_en`=1 and all other outputs 0.
- R2: In RUN, `req_idle`=1 with no bit of `irq_pend` set enters IDLE at the next edge. IDLE drives `cpu_clk_en`=0 with `per_clk_en`=`osc_en`=`port_wr_en`=1. IDLE persists after the request drops.
- R3: In IDLE, any set bit of `irq_pend` returns the block to RUN at the next edge.
- R4: An idle request made in RUN while any `irq_pend` bit is set leaves the block in RUN.
- R5: In RUN, `req_pdown`=1 enters PDOWN at the next edge, even when `req_idle` is also set. PDOWN drives all three clock enables to 0, `int_rst`=0 and `port_wr_en`=1.
- R6: In PDOWN, `irq_pend`, `req_idle` and `req_pdown` have no effect. Only the reset pin, or the brown-out flag, leaves PDOWN.
- R7: `int_rst` falls at the first edge that samples `rst_pin` low only when the latest assertion of the pin was sampled high on at least HOLD_CYC consecutive edges. After a shorter pulse, `int_rst` stays high until a long enough assertion follows.
- R8: A reset pin sampled high in IDLE enters IDLE_RST for exactly WIN_CYC cycles. IDLE_RST drives `cpu_clk_en`=1, `int_rst`=0, `ram_inhibit`=1 and `port_wr_en`=1. Interrupts do not end the window. RESET follows the window.
- R9: While in BROWN, `weak_pu` has every bit set except bits PU_SKIP0 and PU_SKIP1, with `int_rst`=1, `ram_inhibit`=1 and `port_wr_en`=0. In every other state `weak_pu` is all zero.
- R10: After the brown-out flag is sampled low, the RESET output encoding is held for exactly BOD_CYC cycles (BOD_DLY), and then RUN is entered.
- R11: If the brown-out flag returns during BOD_DLY, the block goes back to BROWN. The full BOD_CYC count restarts when the flag clears again.
- R12: Entry priority is the reset pin, then brown-out, then power-down, then idle. A pin asserted together with the flag gives RESET with `weak_pu`=0. Brown-out overrides IDLE, PDOWN and a hold-satisfied RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, synchronous to clk |
| req_idle | input | 1 | Software idle request |
| req_pdown | input | 1 | Software power-down request |
| irq_pend | input | NIRQ | Enabled and pending interrupts |
| bod_flag | input | 1 | Brown-out comparator output, high while supply is low |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset, active high |
| ram_inhibit | output | 1 | Blocks internal RAM access |
| port_wr_en | output | 1 | Allows port-pin writes |
| weak_pu | output | NPIN | Weak pull-up enable per port pin |

## Verification
The bench aims at the edges of each timed window:
- **Reset-pin hold.** A short reset pulse out of power-down must leave `int_rst` high. A design that did not measure the hold would release the core into an oscillator that has not settled.
- **Idle-reset window.** The window must last exactly WIN_CYC cycles, with RAM gated and port writes allowed. A design that jumped straight to reset, or ran without the RAM gate, would show the wrong encoding in those cycles.
- **Brown-out delay.** The release cycle is checked exactly, including after the flag re-asserts part way through. A counter that did not restart would release early.
- **Ignored stimulus.** Interrupts during power-down, and an idle request with an interrupt already pending, are checked at the outputs. So are the priority collisions: pin with brown-out, and both sleep requests together. A wrong priority order would show the wrong state encoding or pull-up mask.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_RUN      = 3'd1,
        ST_IDLE     = 3'd2,
        ST_IDLE_RST = 3'd3,
        ST_PDOWN    = 3'd4,
        ST_BROWN    = 3'd5,
        ST_BOD_DLY  = 3'd6
    } slp_state_e;

    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic osc;
        logic rst;
        logic ram_inh;
        logic port_wr;
        logic pull_up;
    } slp_ctl_t;
endpackage

// File: rtl/slp_tick_cnt.sv
// Counts cycles spent in one state; done marks the last of LIMIT cycles.
module slp_tick_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_in_range: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= LAST);
endmodule

// File: rtl/slp_rst_hold.sv
// Measures how many consecutive edges the latest reset-pin assertion lasted.
module slp_rst_hold #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    output logic hold_ok
);
    localparam int W = $clog2(HOLD_CYC + 1);
    localparam logic [W-1:0] SAT = W'(HOLD_CYC);

    logic         pin_q;
    logic [W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pin_q    <= 1'b0;
            hold_cnt <= SAT;
        end else begin
            pin_q <= rst_pin;
            if (rst_pin && !pin_q) begin
                hold_cnt <= W'(1);
            end else if (rst_pin && hold_cnt != SAT) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    assign hold_ok = (hold_cnt == SAT);

    // R7: the measured length saturates and never runs past the limit
    p_hold_bound_r7: assert property (@(posedge clk) disable iff (!por_n)
        hold_cnt <= SAT);
    // R7: a fresh assertion always starts a new measurement
    p_hold_restart_r7: assert property (@(posedge clk) disable iff (!por_n)
        (rst_pin && !pin_q) |=> (hold_cnt == W'(1)) || (HOLD_CYC == 1));
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin,
    input  logic       req_idle,
    input  logic       req_pdown,
    input  logic       irq_any,
    input  logic       bod_flag,
    input  logic       hold_ok,
    input  logic       win_done,
    input  logic       bod_done,
    output slp_state_e state,
    output slp_ctl_t   ctl
);
    slp_state_e nxt;

    always_comb begin
        nxt = state;
        if (state == ST_IDLE_RST) begin
            nxt = win_done ? ST_RESET : ST_IDLE_RST;
        end else if (rst_pin) begin
            nxt = (state == ST_IDLE) ? ST_IDLE_RST : ST_RESET;
        end else if (bod_flag) begin
            nxt = ST_BROWN;
        end else begin
            unique case (state)
                ST_RESET:    if (hold_ok) nxt = ST_RUN;
                ST_RUN: begin
                    if (req_pdown)                 nxt = ST_PDOWN;
                    else if (req_idle && !irq_any) nxt = ST_IDLE;
                end
                ST_IDLE:     if (irq_any) nxt = ST_RUN;
                ST_PDOWN:    nxt = ST_PDOWN;
                ST_BROWN:    nxt = ST_BOD_DLY;
                ST_BOD_DLY:  if (bod_done) nxt = ST_RUN;
                ST_IDLE_RST: nxt = ST_RESET;
                default:     nxt = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_RUN:      ctl = '{cpu_clk:1'b1, per_clk:1'b1, osc:1'b1, rst:1'b0, ram_inh:1'b0, port_wr:1'b1, pull_up:1'b0};
            ST_IDLE:     ctl = '{cpu_clk:1'b0, per_clk:1'b1, osc:1'b1, rst:1'b0, ram_inh:1'b0, port_wr:1'b1, pull_up:1'b0};
            ST_IDLE_RST: ctl = '{cpu_clk:1'b1, per_clk:1'b1, osc:1'b1, rst:1'b0, ram_inh:1'b1, port_wr:1'b1, pull_up:1'b0};
            ST_PDOWN:    ctl = '{cpu_clk:1'b0, per_clk:1'b0, osc:1'b0, rst:1'b0, ram_inh:1'b0, port_wr:1'b1, pull_up:1'b0};
            ST_BROWN:    ctl = '{cpu_clk:1'b0, per_clk:1'b0, osc:1'b1, rst:1'b1, ram_inh:1'b1, port_wr:1'b0, pull_up:1'b1};
            ST_BOD_DLY:  ctl = '{cpu_clk:1'b0, per_clk:1'b0, osc:1'b1, rst:1'b1, ram_inh:1'b1, port_wr:1'b0, pull_up:1'b0};
            default:     ctl = '{cpu_clk:1'b0, per_clk:1'b0, osc:1'b1, rst:1'b1, ram_inh:1'b1, port_wr:1'b0, pull_up:1'b0};
        endcase
    end

    // R3: a pending interrupt ends idle on the next edge
    p_idle_wake_r3: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_IDLE && irq_any && !rst_pin && !bod_flag) |=> state == ST_RUN);
    // R4: an idle request with an interrupt waiting keeps the core running
    p_no_idle_with_irq_r4: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && req_idle && irq_any && !req_pdown && !rst_pin && !bod_flag)
        |=> state == ST_RUN);
    // R6: nothing but the pin or brown-out leaves power-down
    p_pdown_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_PDOWN && !rst_pin && !bod_flag) |=> state == ST_PDOWN);
    // R8: a pin arriving in idle opens the run window first
    p_window_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_IDLE && rst_pin) |=> state == ST_IDLE_RST);
    // R12: the pin takes precedence over brown-out outside the window
    p_pin_over_bod_r12: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_IDLE && state != ST_IDLE_RST && rst_pin) |=> state == ST_RESET);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import slp_pkg::*;
#(
    parameter int NIRQ     = 5,
    parameter int NPIN     = 15,
    parameter int PU_SKIP0 = 0,
    parameter int PU_SKIP1 = 1,
    parameter int WIN_CYC  = 2,
    parameter int HOLD_CYC = 8,
    parameter int BOD_CYC  = 15000
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            rst_pin,
    input  logic            req_idle,
    input  logic            req_pdown,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic            bod_flag,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            int_rst,
    output logic            ram_inhibit,
    output logic            port_wr_en,
    output logic [NPIN-1:0] weak_pu
);
    slp_state_e state;
    slp_ctl_t   ctl;
    logic       hold_ok;
    logic       win_done;
    logic       bod_done;

    slp_rst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .hold_ok(hold_ok)
    );

    slp_tick_cnt #(.LIMIT(WIN_CYC)) u_win (
        .clk(clk), .por_n(por_n), .run(state == ST_IDLE_RST), .done(win_done)
    );

    slp_tick_cnt #(.LIMIT(BOD_CYC)) u_bod (
        .clk(clk), .por_n(por_n), .run(state == ST_BOD_DLY), .done(bod_done)
    );

    slp_fsm u_fsm (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .req_idle(req_idle),
        .req_pdown(req_pdown), .irq_any(|irq_pend), .bod_flag(bod_flag),
        .hold_ok(hold_ok), .win_done(win_done), .bod_done(bod_done),
        .state(state), .ctl(ctl)
    );

    assign cpu_clk_en  = ctl.cpu_clk;
    assign per_clk_en  = ctl.per_clk;
    assign osc_en      = ctl.osc;
    assign int_rst     = ctl.rst;
    assign ram_inhibit = ctl.ram_inh;
    assign port_wr_en  = ctl.port_wr;

    for (genvar i = 0; i < NPIN; i++) begin : g_pu
        if (i == PU_SKIP0 || i == PU_SKIP1) begin : g_skip
            assign weak_pu[i] = 1'b0;
        end else begin : g_drive
            assign weak_pu[i] = ctl.pull_up;
        end
    end

    // R5: no clock can run while the oscillator is stopped
    p_osc_off_r5: assert property (@(posedge clk) disable iff (!por_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));
    // R8: RAM gated without reset only in the window where the CPU still runs
    p_window_outputs_r8: assert property (@(posedge clk) disable iff (!por_n)
        (ram_inhibit && !int_rst) |-> (cpu_clk_en && port_wr_en));
    // R9: pull-ups appear only under reset and never on the excluded pins
    p_pu_mask_r9: assert property (@(posedge clk) disable iff (!por_n)
        (weak_pu != '0) |-> (int_rst && !weak_pu[PU_SKIP0] && !weak_pu[PU_SKIP1]));
    // R7: the internal reset falls only after a long enough pin assertion
    p_release_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(int_rst) && $past(state) == ST_RESET) |-> $past(hold_ok));
endmodule

// File: tb/sleep_ctrl_test.sv
`timescale 1ns/100ps
module sleep_ctrl_test;
    localparam int NIRQ = 5;
    localparam int NPIN = 15;
    localparam int WIN  = 2;
    localparam int HOLD = 4;
    localparam int BOD  = 10;
    localparam int VW   = 6 + NPIN;

    // cpu, per, osc, rst, ram_inhibit, port_wr
    localparam logic [5:0] E_RUN  = 6'b111001;
    localparam logic [5:0] E_IDLE = 6'b011001;
    localparam logic [5:0] E_IRST = 6'b111011;
    localparam logic [5:0] E_PD   = 6'b000001;
    localparam logic [5:0] E_RST  = 6'b001110;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            rst_pin = 1'b0;
    logic            req_idle = 1'b0;
    logic            req_pdown = 1'b0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic            bod_flag = 1'b0;
    logic            cpu_clk_en, per_clk_en, osc_en, int_rst, ram_inhibit, port_wr_en;
    logic [NPIN-1:0] weak_pu;

    int n_chk = 0;
    int n_fail = 0;
    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    sleep_ctrl #(.NIRQ(NIRQ), .NPIN(NPIN), .PU_SKIP0(0), .PU_SKIP1(1),
                 .WIN_CYC(WIN), .HOLD_CYC(HOLD), .BOD_CYC(BOD)) uut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .req_idle(req_idle),
        .req_pdown(req_pdown), .irq_pend(irq_pend), .bod_flag(bod_flag),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .int_rst(int_rst), .ram_inhibit(ram_inhibit), .port_wr_en(port_wr_en),
        .weak_pu(weak_pu)
    );

    function automatic logic [NPIN-1:0] pu_mask();
        logic [NPIN-1:0] m = '0;
        for (int i = 2; i < NPIN; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [VW-1:0] observed();
        return {cpu_clk_en, per_clk_en, osc_en, int_rst, ram_inhibit, port_wr_en, weak_pu};
    endfunction

    task automatic compare(input logic [VW-1:0] exp, input string tag);
        logic [VW-1:0] act = observed();
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus and the outputs expected after the next edge.
    task automatic cyc(input bit idle, input bit pd, input logic [NIRQ-1:0] irq,
                       input bit bod, input bit pin, input logic [5:0] st,
                       input bit pu, input string tag);
        @(negedge clk);
        req_idle  = idle;
        req_pdown = pd;
        irq_pend  = irq;
        bod_flag  = bod;
        rst_pin   = pin;
        exp_q.push_back({st, pu ? pu_mask() : {NPIN{1'b0}}});
        tag_q.push_back(tag);
    endtask

    task automatic rep(input int n, input bit bod, input bit pin,
                       input logic [5:0] st, input bit pu, input string tag);
        for (int k = 0; k < n; k++) cyc(0, 0, '0, bod, pin, st, pu, tag);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: sample just after each edge and compare with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare({E_RST, {NPIN{1'b0}}}, "R1 por state");
        @(negedge clk);
        por_n = 1'b1;
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R1 first run");

        // Idle entry and interrupt wake
        cyc(1, 0, '0, 0, 0, E_IDLE, 0, "R2 enter idle");
        rep(3, 0, 0, E_IDLE, 0, "R2 idle holds");
        cyc(0, 0, 5'b00100, 0, 0, E_RUN, 0, "R3 wake irq2");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R3 stays run");
        cyc(1, 0, '0, 0, 0, E_IDLE, 0, "R2 enter idle again");
        cyc(0, 0, 5'b10000, 0, 0, E_RUN, 0, "R3 wake irq4");

        // Idle request with an interrupt already pending
        cyc(1, 0, 5'b00001, 0, 0, E_RUN, 0, "R4 idle refused");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R4 still run");

        // Power-down: wins over idle, ignores interrupts and requests
        cyc(1, 1, '0, 0, 0, E_PD, 0, "R5 pdown over idle");
        cyc(0, 0, '1, 0, 0, E_PD, 0, "R6 irq ignored");
        cyc(1, 0, '1, 0, 0, E_PD, 0, "R6 idle req ignored");
        cyc(0, 1, '0, 0, 0, E_PD, 0, "R6 pdown req ignored");

        // Short pin pulse out of power-down, then a long one
        rep(2, 0, 1, E_RST, 0, "R7 pin short");
        rep(2, 0, 0, E_RST, 0, "R7 short pulse holds reset");
        rep(HOLD, 0, 1, E_RST, 0, "R7 pin long");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R7 release after hold");

        // Reset pin during idle: run window then reset
        cyc(1, 0, '0, 0, 0, E_IDLE, 0, "R2 idle before pin");
        cyc(0, 0, '0, 0, 1, E_IRST, 0, "R8 window cycle 1");
        cyc(0, 0, '1, 0, 1, E_IRST, 0, "R8 window cycle 2 irq ignored");
        cyc(0, 0, '0, 0, 1, E_RST, 0, "R8 window ends in reset");
        cyc(0, 0, '0, 0, 1, E_RST, 0, "R8 reset held");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R7 release after window");

        // Brown-out, timed release
        rep(2, 1, 0, E_RST, 1, "R9 brown-out pull-ups");
        rep(BOD, 0, 0, E_RST, 0, "R10 delay holds reset");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R10 release after delay");

        // Brown-out returning during the delay restarts it
        cyc(0, 0, '0, 1, 0, E_RST, 1, "R9 brown-out");
        rep(5, 0, 0, E_RST, 0, "R11 partial delay");
        cyc(0, 0, '0, 1, 0, E_RST, 1, "R11 brown-out returns");
        rep(BOD, 0, 0, E_RST, 0, "R11 full delay again");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R11 release after restart");

        // Priorities
        cyc(1, 0, '0, 0, 0, E_IDLE, 0, "R2 idle before brown-out");
        cyc(0, 0, '0, 1, 0, E_RST, 1, "R12 brown-out ends idle");
        rep(HOLD, 1, 1, E_RST, 0, "R12 pin over brown-out");
        cyc(0, 0, '0, 1, 0, E_RST, 1, "R12 brown-out over release");
        rep(BOD, 0, 0, E_RST, 0, "R10 delay after priority");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R10 release");
        cyc(0, 1, '0, 0, 0, E_PD, 0, "R5 enter pdown");
        cyc(0, 0, '0, 1, 0, E_RST, 1, "R12 brown-out over pdown");
        rep(BOD, 0, 0, E_RST, 0, "R10 delay after pdown");
        cyc(0, 0, '0, 0, 0, E_RUN, 0, "R10 release from pdown");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule